// File: doc/BRIEF.md
# Vector Byte Table Gather Unit

This unit assembles a 64-bit result from eight independently chosen bytes. The bytes come from a table built from one to four adjacent 128-bit registers. The registers live in a 32-entry vector register file held inside the unit, and software-visible writes load that file through a single write port. A lookup presents four things:

- an index word holding eight 8-bit indices;
- the number of the register where the table begins;
- the number of registers in the table;
- an initial result word.

Each index picks one byte of the table and places it in the matching lane of the result. An index beyond the end of the table does not fetch anything. In zeroing mode the lane becomes zero. In extension mode the lane keeps the byte of the initial result word. The table is a chain of 64-bit halves. It runs past register 31 and continues at register 0.

Control is a two-state machine:

- `ST_IDLE`: no result is being presented.
- `ST_HOLD`: the result captured on the last strobe is valid.

The transitions are:

- `IDLE_TO_HOLD`: taken on a request.
- `HOLD_STAY`: a back-to-back request, taken on a request while in `ST_HOLD`.
- `HOLD_TO_IDLE`: taken when no request arrives.
- `IDLE_STAY`: taken when there is still no request.

The result register loads only on a request and otherwise keeps its value.

Top module: `byte_gather_unit`

## Requirements
- R1: While reset is asserted, and after it, until the first request, `result` is zero and `result_valid` is low.
- R2: `result_valid` is high in exactly the cycle after a cycle in which `lookup_req` was high, and low otherwise.
- R3: Result lane k (bits [8k+7:8k]) is produced by the index in bits [8k+7:8k] of `idx_word`, for k = 0 to 7.
- R4: An index is in range only when its unsigned value is below 16 times the effective register count.
- R5: The effective register count is `tbl_count` for values 1 to 4. A value of 0 counts as 1, and values 5 to 7 count as 4.
- R6: With `ext_mode` = 1, an out-of-range lane takes the same lane of `init_word`.
- R7: With `ext_mode` = 0, an out-of-range lane is zero, whatever `init_word` holds.
- R8: For an in-range index i, the source is 64-bit half h = (2*`tbl_base` + i[7:3]) mod 64. Half h is register h/2, bits [63:0] when h is even and bits [127:64] when h is odd. The byte taken is bits [8*i[2:0]+7 : 8*i[2:0]] of that half.
- R9: The table wraps from register 31 to register 0 (for example, a base of 31 with two registers reads registers 31 and 0).
- R10: When `wr_en` is high, `wr_data` is stored in register `wr_reg` at the clock edge. A lookup requested in the same cycle sees the old contents, and later lookups see the new contents.
- R11: In a cycle without `lookup_req`, `result` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register file write strobe |
| wr_reg | input | 5 | Register number to write |
| wr_data | input | 128 | Data for the register write |
| lookup_req | input | 1 | Lookup request strobe |
| idx_word | input | 64 | Eight byte indices, lane k in bits [8k+7:8k] |
| tbl_base | input | 5 | First register of the table |
| tbl_count | input | 3 | Number of table registers (normalised per R5) |
| ext_mode | input | 1 | 1 keeps initial lanes for out-of-range indices, 0 zeroes them |
| init_word | input | 64 | Initial result word |
| result | output | 64 | Registered gathered result |
| result_valid | output | 1 | High in the cycle after a request |

## Verification
The assertions assume the following about the inputs:

- reset is held low from time zero for at least one clock edge;
- `lookup_req`, `ext_mode`, `idx_word`, `tbl_count` and `init_word` are known and settled at each rising edge;
- the lane properties for out-of-range indices use only indices at or above 64, or at or above 16 when the count is zero, so they hold for any base and any register file contents.

The stimulus drives every input on the falling edge and holds reset low from the start. It sweeps all 256 index values across every count encoding, both modes and base registers at the start, middle and wrapping end of the file. It also exercises a write that coincides with a lookup on the register being written.

// File: rtl/bgu_pkg.sv
package bgu_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } bgu_state_e;

    localparam int BGU_BYTE_W = 8;

endpackage

// File: rtl/bgu_regfile.sv
module bgu_regfile #(
    parameter int NUM_REGS = 32,
    parameter int REG_W    = 128,
    parameter int RD_PORTS = 8,
    localparam int REG_AW  = $clog2(NUM_REGS),
    localparam int HALF_W  = REG_W / 2,
    localparam int HALF_AW = REG_AW + 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [REG_AW-1:0]                wr_reg,
    input  logic [REG_W-1:0]                 wr_data,
    input  logic [RD_PORTS-1:0][HALF_AW-1:0] rd_half,
    output logic [RD_PORTS-1:0][HALF_W-1:0]  rd_data
);

    logic [NUM_REGS-1:0][REG_W-1:0] regs_q;

    // Write port: the new value is visible only after the edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < NUM_REGS; r++) begin
                regs_q[r] <= '0;
            end
        end else if (wr_en) begin
            regs_q[wr_reg] <= wr_data;
        end
    end

    // One combinational half-register read port per lane.
    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
        logic [REG_AW-1:0] rsel;
        assign rsel = rd_half[p][HALF_AW-1:1];
        always_comb begin
            if (rd_half[p][0]) begin
                rd_data[p] = regs_q[rsel][REG_W-1:HALF_W];
            end else begin
                rd_data[p] = regs_q[rsel][HALF_W-1:0];
            end
        end
    end

endmodule

// File: rtl/bgu_lane.sv
module bgu_lane #(
    parameter int NUM_REGS = 32,
    parameter int REG_W    = 128,
    parameter int LIM_W    = 7,
    localparam int BYTE_W  = bgu_pkg::BGU_BYTE_W,
    localparam int REG_AW  = $clog2(NUM_REGS),
    localparam int HALF_W  = REG_W / 2,
    localparam int HALF_AW = REG_AW + 1,
    localparam int SEL_W   = $clog2(HALF_W / BYTE_W)
) (
    input  logic [BYTE_W-1:0]  idx,
    input  logic [REG_AW-1:0]  base,
    input  logic [LIM_W-1:0]   limit,
    input  logic               ext_mode,
    input  logic [BYTE_W-1:0]  init_byte,
    output logic [HALF_AW-1:0] half_addr,
    input  logic [HALF_W-1:0]  half_data,
    output logic [BYTE_W-1:0]  lane_byte
);

    logic [HALF_AW-1:0] half_off;
    logic [SEL_W-1:0]   byte_sel;
    logic               in_range;
    logic [BYTE_W-1:0]  fetched;

    // Half offset from the upper index bits; the sum wraps modulo the half count.
    assign half_off  = HALF_AW'(idx[BYTE_W-1:SEL_W]);
    assign half_addr = {base, 1'b0} + half_off;
    assign byte_sel  = idx[SEL_W-1:0];
    assign in_range  = int'(idx) < int'(limit);

    always_comb begin
        fetched = half_data[byte_sel*BYTE_W +: BYTE_W];
        if (in_range) begin
            lane_byte = fetched;
        end else if (ext_mode) begin
            lane_byte = init_byte;
        end else begin
            lane_byte = '0;
        end
    end

endmodule

// File: rtl/bgu_ctrl.sv
module bgu_ctrl #(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lookup_req,
    input  logic [DATA_W-1:0] next_result,
    output logic [DATA_W-1:0] result,
    output logic              result_valid
);
    import bgu_pkg::*;

    bgu_state_e state_q, state_d;
    logic [DATA_W-1:0] result_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = lookup_req ? ST_HOLD : ST_IDLE;  // IDLE_TO_HOLD / IDLE_STAY
            ST_HOLD: state_d = lookup_req ? ST_HOLD : ST_IDLE;  // HOLD_STAY / HOLD_TO_IDLE
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs: result loads on a request and holds otherwise.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q <= '0;
        end else if (lookup_req) begin
            result_q <= next_result;
        end
    end

    assign result       = result_q;
    assign result_valid = (state_q == ST_HOLD);

endmodule

// File: rtl/byte_gather_unit.sv
module byte_gather_unit #(
    parameter int NUM_REGS = 32,
    parameter int REG_W    = 128,
    parameter int IDX_W    = 64,
    parameter int MAX_CNT  = 4,
    localparam int BYTE_W    = bgu_pkg::BGU_BYTE_W,
    localparam int LANES     = IDX_W / BYTE_W,
    localparam int REG_AW    = $clog2(NUM_REGS),
    localparam int HALF_W    = REG_W / 2,
    localparam int HALF_AW   = REG_AW + 1,
    localparam int REG_BYTES = REG_W / BYTE_W,
    localparam int CNT_W     = $clog2(MAX_CNT) + 1,
    localparam int LIM_W     = $clog2(MAX_CNT * REG_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_reg,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              lookup_req,
    input  logic [IDX_W-1:0]  idx_word,
    input  logic [REG_AW-1:0] tbl_base,
    input  logic [CNT_W-1:0]  tbl_count,
    input  logic              ext_mode,
    input  logic [IDX_W-1:0]  init_word,
    output logic [IDX_W-1:0]  result,
    output logic              result_valid
);

    logic [CNT_W-1:0]               cnt_eff;
    logic [LIM_W-1:0]               limit;
    logic [LANES-1:0][HALF_AW-1:0]  rd_half;
    logic [LANES-1:0][HALF_W-1:0]   rd_data;
    logic [IDX_W-1:0]               gathered;

    // Count normalisation: zero means one, above the maximum clamps.
    always_comb begin
        if (tbl_count == '0) begin
            cnt_eff = CNT_W'(1);
        end else if (int'(tbl_count) > MAX_CNT) begin
            cnt_eff = CNT_W'(MAX_CNT);
        end else begin
            cnt_eff = tbl_count;
        end
        limit = LIM_W'(cnt_eff) << $clog2(REG_BYTES);
    end

    bgu_regfile #(
        .NUM_REGS (NUM_REGS),
        .REG_W    (REG_W),
        .RD_PORTS (LANES)
    ) u_regfile (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_reg  (wr_reg),
        .wr_data (wr_data),
        .rd_half (rd_half),
        .rd_data (rd_data)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        bgu_lane #(
            .NUM_REGS (NUM_REGS),
            .REG_W    (REG_W),
            .LIM_W    (LIM_W)
        ) u_lane (
            .idx       (idx_word[k*BYTE_W +: BYTE_W]),
            .base      (tbl_base),
            .limit     (limit),
            .ext_mode  (ext_mode),
            .init_byte (init_word[k*BYTE_W +: BYTE_W]),
            .half_addr (rd_half[k]),
            .half_data (rd_data[k]),
            .lane_byte (gathered[k*BYTE_W +: BYTE_W])
        );
    end

    bgu_ctrl #(
        .DATA_W (IDX_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .lookup_req   (lookup_req),
        .next_result  (gathered),
        .result       (result),
        .result_valid (result_valid)
    );

endmodule

// File: rtl/bgu_checker.sv
module bgu_checker #(
    parameter int IDX_W     = 64,
    parameter int CNT_W     = 3,
    parameter int REG_BYTES = 16,
    parameter int MAX_CNT   = 4,
    localparam int BYTE_W   = 8,
    localparam int LANES    = IDX_W / BYTE_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lookup_req,
    input logic [IDX_W-1:0] idx_word,
    input logic [CNT_W-1:0] tbl_count,
    input logic             ext_mode,
    input logic [IDX_W-1:0] init_word,
    input logic [IDX_W-1:0] result,
    input logic             result_valid
);

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (result == '0 && !result_valid));

    a_r2_valid_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        lookup_req |=> result_valid);

    a_r2_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !lookup_req |=> !result_valid);

    a_r11_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !lookup_req |=> $stable(result));

    for (genvar k = 0; k < LANES; k++) begin : g_lane_chk
        logic [BYTE_W-1:0] ix;
        assign ix = idx_word[k*BYTE_W +: BYTE_W];

        a_r7_zero_lane: assert property (@(posedge clk) disable iff (!rst_n)
            (lookup_req && !ext_mode && int'(ix) >= MAX_CNT * REG_BYTES)
            |=> result[k*BYTE_W +: BYTE_W] == '0);

        a_r6_keep_lane: assert property (@(posedge clk) disable iff (!rst_n)
            (lookup_req && ext_mode && int'(ix) >= MAX_CNT * REG_BYTES)
            |=> result[k*BYTE_W +: BYTE_W] == $past(init_word[k*BYTE_W +: BYTE_W]));

        a_r5_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
            (lookup_req && !ext_mode && tbl_count == '0 && int'(ix) >= REG_BYTES)
            |=> result[k*BYTE_W +: BYTE_W] == '0);
    end

endmodule

bind byte_gather_unit bgu_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lookup_req   (lookup_req),
    .idx_word     (idx_word),
    .tbl_count    (tbl_count),
    .ext_mode     (ext_mode),
    .init_word    (init_word),
    .result       (result),
    .result_valid (result_valid)
);

// File: tb/byte_gather_unit_bench.sv
module byte_gather_unit_bench;

    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [4:0]   wr_reg = '0;
    logic [127:0] wr_data = '0;
    logic         lookup_req = 1'b0;
    logic [63:0]  idx_word = '0;
    logic [4:0]   tbl_base = '0;
    logic [2:0]   tbl_count = '0;
    logic         ext_mode = 1'b0;
    logic [63:0]  init_word = '0;
    logic [63:0]  result;
    logic         result_valid;

    logic [127:0] mirror [32];
    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    byte_gather_unit u_byte_gather_unit (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_reg(wr_reg), .wr_data(wr_data),
        .lookup_req(lookup_req), .idx_word(idx_word), .tbl_base(tbl_base),
        .tbl_count(tbl_count), .ext_mode(ext_mode), .init_word(init_word),
        .result(result), .result_valid(result_valid)
    );

    function automatic logic [7:0] pattern_byte(int r, int b, int salt);
        return 8'((r * 37 + b * 11 + salt * 101 + 3) & 8'hFF);
    endfunction

    function automatic logic [63:0] model(logic [63:0] idx, int base, int cnt, bit ext,
                                          logic [63:0] init);
        logic [63:0] res;
        int n, i, h;
        n = (cnt == 0) ? 1 : ((cnt > 4) ? 4 : cnt);
        for (int k = 0; k < 8; k++) begin
            i = int'(idx[8*k +: 8]);
            if (i < 16 * n) begin
                h = (2 * base + i / 8) % 64;
                res[8*k +: 8] = mirror[h / 2][64 * (h % 2) + 8 * (i % 8) +: 8];
            end else begin
                res[8*k +: 8] = ext ? init[8*k +: 8] : 8'h00;
            end
        end
        return res;
    endfunction

    task automatic check64(string tag, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic write_reg(int r, logic [127:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_reg = 5'(r); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        mirror[r] = d;
    endtask

    task automatic lookup(string tag, logic [63:0] idx, int base, int cnt, bit ext,
                          logic [63:0] init);
        logic [63:0] exp;
        exp = model(idx, base, cnt, ext, init);
        @(negedge clk);
        lookup_req = 1'b1; idx_word = idx; tbl_base = 5'(base);
        tbl_count = 3'(cnt); ext_mode = ext; init_word = init;
        @(negedge clk);
        lookup_req = 1'b0;
        check64(tag, result, exp);
        check64("R2", {63'd0, result_valid}, 64'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] held;
        logic [63:0] idx;
        string tag;
        for (int r = 0; r < 32; r++) mirror[r] = '0;

        // R1: reset state
        repeat (3) @(negedge clk);
        check64("R1", result, 64'd0);
        check64("R1", {63'd0, result_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check64("R1", result, 64'd0);
        check64("R1", {63'd0, result_valid}, 64'd0);

        // Load the register file through the write port (R10)
        for (int r = 0; r < 32; r++) begin
            logic [127:0] d;
            for (int b = 0; b < 16; b++) d[8*b +: 8] = pattern_byte(r, b, 0);
            write_reg(r, d);
        end

        // Directed cases
        lookup("R3", 64'h0001_0203_0405_0607, 0, 1, 1'b0, 64'h0);
        lookup("R3", 64'h0F0E_0908_0706_0100, 7, 1, 1'b1, 64'h1122_3344_5566_7788);
        lookup("R4", 64'h2021_1F1E_2000_1F3F, 3, 2, 1'b1, 64'hCAFE_F00D_DEAD_BEEF);
        lookup("R6", 64'hFFFF_FFFF_FFFF_FFFF, 12, 4, 1'b1, 64'h0123_4567_89AB_CDEF);
        lookup("R7", 64'hFF80_4140_FF80_4140, 12, 4, 1'b0, 64'h0123_4567_89AB_CDEF);
        lookup("R8", 64'h3F38_3730_2F28_1F10, 20, 4, 1'b0, 64'h0);
        lookup("R9", 64'h3F30_2F20_1F10_0F00, 31, 4, 1'b0, 64'h0);
        lookup("R5", 64'h1011_3F0F_0001_4010, 9, 0, 1'b1, 64'h5555_AAAA_5555_AAAA);
        lookup("R5", 64'h4041_3F3E_3000_2010, 9, 7, 1'b1, 64'h5555_AAAA_5555_AAAA);

        // R11 / R2: result holds and valid drops without a request
        held = result;
        repeat (3) begin
            @(negedge clk);
            check64("R11", result, held);
            check64("R2", {63'd0, result_valid}, 64'd0);
        end

        // R10: write coinciding with a lookup of the same register
        begin
            logic [127:0] nd;
            logic [63:0] exp_old, exp_new;
            for (int b = 0; b < 16; b++) nd[8*b +: 8] = pattern_byte(5, b, 1);
            idx = 64'h0F0E_0D0C_0302_0100;
            exp_old = model(idx, 5, 1, 1'b0, 64'h0);
            @(negedge clk);
            wr_en = 1'b1; wr_reg = 5'd5; wr_data = nd;
            lookup_req = 1'b1; idx_word = idx; tbl_base = 5'd5;
            tbl_count = 3'd1; ext_mode = 1'b0; init_word = 64'h0;
            @(negedge clk);
            wr_en = 1'b0; lookup_req = 1'b0;
            check64("R10", result, exp_old);
            mirror[5] = nd;
            exp_new = model(idx, 5, 1, 1'b0, 64'h0);
            check64("R10", {63'd0, (exp_new != exp_old)}, 64'd1);
            lookup("R10", idx, 5, 1, 1'b0, 64'h0);
        end

        // Sweep: all index values, every count encoding, both modes, several bases
        foreach (idx[i]) idx[i] = 1'b0;
        for (int bi = 0; bi < 3; bi++) begin
            int base;
            base = (bi == 0) ? 0 : ((bi == 1) ? 14 : 31);
            for (int cnt = 0; cnt < 8; cnt++) begin
                for (int ex = 0; ex < 2; ex++) begin
                    for (int g = 0; g < 32; g++) begin
                        logic [63:0] init;
                        for (int k = 0; k < 8; k++) idx[8*k +: 8] = 8'(g * 8 + (k ^ (g & 7)));
                        init = 64'hA5C3_0F1E_2D3C_4B5A ^ {8{8'(g)}};
                        if (cnt == 0 || cnt > 4) tag = "R5";
                        else if (g >= 2 * cnt) tag = (ex != 0) ? "R6" : "R7";
                        else if (base == 31) tag = "R9";
                        else tag = "R8";
                        lookup(tag, idx, base, cnt, ex[0], init);
                    end
                end
            end
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule